// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects a synchronous request port to an external asynchronous static RAM with 19 address bits, 16 data bits and two byte lanes. A client offers one single-word read or write at a time through a valid/ready handshake. Each request carries an address, write data and a two-bit lane mask. The controller plays the request out on registered active-low strobes: chip select, output enable, write strobe, and the low and high lane enables. The data bus is bidirectional. Read results come back with a one-cycle valid pulse.

Every phase length is a whole number of clock cycles. Each one is computed from a nanosecond parameter divided by the clock period, rounded up, with a floor of one cycle. The parameters are the access time, the output-enable-to-data time, the write pulse width, the data setup time, the write-strobe-to-float time of the memory, the read-to-write turnaround and the power-up wait. The block drives the data bus only while the memory is known to be floating. It also holds off all traffic until the power-up wait has elapsed.

Top module: `sram_access_ctrl`

## Requirements
- R1: After reset, and until the wake wait ends, all five strobes are high, the bus is not driven and `req_ready` is low. `req_ready` first reads high POWERUP_CYC+1 clock edges after reset is released, with POWERUP_CYC = ceil(POWERUP_NS / CLK_PERIOD_NS).
- R2: A read holds `mem_cs_n` and `mem_oe_n` low and `mem_we_n` high for exactly RD_CYC cycles, where RD_CYC = max(ceil(T_ACCESS_NS/period), ceil(T_OE_NS/period)). `mem_lo_n` is low exactly when `req_lanes[0]` was 1, and `mem_hi_n` exactly when `req_lanes[1]` was 1.
- R3: Every accepted read produces exactly one `rsp_valid` pulse, RD_CYC clock edges after the accepting edge. Bits 7:0 of `rsp_rdata` hold the memory's low lane when `req_lanes[0]` was 1, bits 15:8 hold the high lane when `req_lanes[1]` was 1, and a deselected lane reads zero.
- R4: A write holds `mem_cs_n` and `mem_we_n` low and `mem_oe_n` high. The lane enables follow the mask as in R2. The write strobe stays low for WZ_CYC + WDATA_CYC cycles, with WDATA_CYC = max(ceil(T_SETUP_NS/period), ceil(T_WPULSE_NS/period) - WZ_CYC, 1).
- R5: The controller drives `mem_dq` only while `mem_oe_n` is high. The drive starts WZ_CYC cycles after the write strobe falls and carries the request's write data until the strobe rises. The drive is released one cycle after the strobe rises.
- R6: A lane mask of 00 changes nothing. A write with mask 00 leaves the stored word unchanged, and a read with mask 00 returns 0.
- R7: After a read, `mem_cs_n` and `mem_oe_n` stay high for at least TURN_CYC+1 cycles before the next access begins, with TURN_CYC = ceil(T_TURN_NS/period).
- R8: Whenever `req_ready` is high, every strobe is high and the bus is released.
- R9: `req_ready` is low for every cycle of an access and of the turnaround, so a request is taken only in the idle state.
- R10: A partial write changes only the lanes it selects, and the other lane keeps its earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_lanes | input | 2 | Lane select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_rdata | output | 16 | Read result, deselected lanes zero |
| mem_addr | output | 19 | Memory address |
| mem_dq | inout | 16 | Memory data bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_lo_n | output | 1 | Low lane enable, active low |
| mem_hi_n | output | 1 | High lane enable, active low |

## Verification
The memory is written and read with all three non-empty lane masks on one address. This separates a correct lane merge from one that swaps lanes, ignores the mask or clears the other lane. The empty mask is applied to both a write and a read to show that it touches nothing. Reads of never-written addresses at both ends of the address space expose address truncation. A read placed directly before a write measures the turnaround gap. A mixed sequence over a spread of addresses checks response latency and strobe lengths under repeated traffic.

// File: rtl/sac_pkg.sv
package sac_pkg;

    localparam int ADDR_W = 19;
    localparam int DATA_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    typedef enum logic [2:0] {
        ST_WAKE,
        ST_IDLE,
        ST_RD,
        ST_TURN,
        ST_WR_HIZ,
        ST_WR_DATA,
        ST_WR_HOLD
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic hi_n;
        logic lo_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, hi_n: 1'b1, lo_n: 1'b1};

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LANES-1:0]  lanes;
    } req_t;

    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] lanes);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[i*LANE_W +: LANE_W] = {LANE_W{lanes[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/sac_wake_timer.sv
module sac_wake_timer #(
    parameter int WAIT_CYC = 5000
) (
    input  logic clk,
    input  logic rst,
    output logic wake_done
);
    localparam int CW = $clog2(WAIT_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            wake_done <= 1'b0;
        end else if (!wake_done) begin
            if (cnt == CW'(WAIT_CYC - 1)) begin
                wake_done <= 1'b1;
            end
            cnt <= cnt + 1'b1;
        end
    end

    AST_WAKE_STICKY: assert property (@(posedge clk) disable iff (rst)
        wake_done |=> wake_done); // R1

endmodule

// File: rtl/sac_phase_timer.sv
module sac_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == '0);

endmodule

// File: rtl/sac_sequencer.sv
module sac_sequencer
    import sac_pkg::*;
#(
    parameter int RD_CYC    = 1,
    parameter int WZ_CYC    = 1,
    parameter int WDATA_CYC = 1,
    parameter int TURN_CYC  = 1,
    parameter int CW        = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wake_done,
    input  logic              req_valid,
    input  req_t              req,
    output logic              req_ready,
    input  logic              timer_expire,
    output logic              timer_load,
    output logic [CW-1:0]     timer_val,
    output strobe_t           strb,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int WLOW_CYC = WZ_CYC + WDATA_CYC;
    localparam int RUN_W    = $clog2(imax(WLOW_CYC, RD_CYC) + 2);

    seq_state_t       state;
    logic [LANES-1:0] lanes_q;

    assign req_ready = (state == ST_IDLE);

    always_comb begin
        timer_load = 1'b0;
        timer_val  = '0;
        case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    timer_load = 1'b1;
                    timer_val  = req.wr ? CW'(WZ_CYC - 1) : CW'(RD_CYC - 1);
                end
            end
            ST_RD: begin
                if (timer_expire) begin
                    timer_load = 1'b1;
                    timer_val  = CW'(TURN_CYC - 1);
                end
            end
            ST_WR_HIZ: begin
                if (timer_expire) begin
                    timer_load = 1'b1;
                    timer_val  = CW'(WDATA_CYC - 1);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_WAKE;
            strb      <= STROBE_IDLE;
            mem_addr  <= '0;
            dq_out    <= '0;
            dq_oe     <= 1'b0;
            lanes_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_WAKE: begin
                    if (wake_done) state <= ST_IDLE;
                end
                ST_IDLE: begin
                    if (req_valid) begin
                        mem_addr  <= req.addr;
                        dq_out    <= req.data;
                        lanes_q   <= req.lanes;
                        strb.cs_n <= 1'b0;
                        strb.lo_n <= ~req.lanes[0];
                        strb.hi_n <= ~req.lanes[1];
                        if (req.wr) begin
                            strb.we_n <= 1'b0;
                            state     <= ST_WR_HIZ;
                        end else begin
                            strb.oe_n <= 1'b0;
                            state     <= ST_RD;
                        end
                    end
                end
                ST_RD: begin
                    if (timer_expire) begin
                        rsp_valid <= 1'b1;
                        rsp_data  <= dq_in & lane_mask(lanes_q);
                        strb      <= STROBE_IDLE;
                        state     <= ST_TURN;
                    end
                end
                ST_TURN: begin
                    if (timer_expire) state <= ST_IDLE;
                end
                ST_WR_HIZ: begin
                    if (timer_expire) begin
                        dq_oe <= 1'b1;
                        state <= ST_WR_DATA;
                    end
                end
                ST_WR_DATA: begin
                    if (timer_expire) begin
                        strb  <= STROBE_IDLE;
                        state <= ST_WR_HOLD;
                    end
                end
                ST_WR_HOLD: begin
                    dq_oe <= 1'b0;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // run-length counters for strobe-width checks
    logic [RUN_W-1:0] we_run;
    logic [RUN_W-1:0] rd_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_run <= '0;
            rd_run <= '0;
        end else begin
            we_run <= strb.we_n ? '0 : we_run + 1'b1;
            rd_run <= strb.oe_n ? '0 : rd_run + 1'b1;
        end
    end

    AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !wake_done |-> (strb == STROBE_IDLE) && !dq_oe && !req_ready); // R1

    AST_RD_DIRECTION: assert property (@(posedge clk) disable iff (rst)
        !strb.oe_n |-> strb.we_n && !strb.cs_n); // R2

    AST_RD_SPAN: assert property (@(posedge clk) disable iff (rst)
        $rose(strb.oe_n) |-> rd_run == RUN_W'(RD_CYC)); // R2

    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R3

    AST_WE_SPAN: assert property (@(posedge clk) disable iff (rst)
        $rose(strb.we_n) |-> we_run == RUN_W'(WLOW_CYC)); // R4

    AST_NO_CLASH: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> strb.oe_n); // R5

    AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (dq_oe && !strb.cs_n) |-> !strb.we_n); // R5

    AST_TURN_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(strb.oe_n) |=> strb.cs_n && strb.oe_n); // R7

    AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (strb == STROBE_IDLE) && !dq_oe); // R8

endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
    import sac_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter int T_ACCESS_NS   = 10,
    parameter int T_OE_NS       = 5,
    parameter int T_WPULSE_NS   = 7,
    parameter int T_SETUP_NS    = 5,
    parameter int T_WZ_NS       = 5,
    parameter int T_TURN_NS     = 5,
    parameter int POWERUP_NS    = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_lanes,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_lo_n,
    output logic              mem_hi_n
);
    localparam int RD_CYC      = imax(ns_to_cyc(T_ACCESS_NS, CLK_PERIOD_NS),
                                      ns_to_cyc(T_OE_NS, CLK_PERIOD_NS));
    localparam int WZ_CYC      = ns_to_cyc(T_WZ_NS, CLK_PERIOD_NS);
    localparam int PULSE_CYC   = ns_to_cyc(T_WPULSE_NS, CLK_PERIOD_NS);
    localparam int SETUP_CYC   = ns_to_cyc(T_SETUP_NS, CLK_PERIOD_NS);
    localparam int WDATA_CYC   = imax(imax(SETUP_CYC, PULSE_CYC - WZ_CYC), 1);
    localparam int TURN_CYC    = ns_to_cyc(T_TURN_NS, CLK_PERIOD_NS);
    localparam int POWERUP_CYC = ns_to_cyc(POWERUP_NS, CLK_PERIOD_NS);
    localparam int MAX_CYC     = imax(imax(RD_CYC, WZ_CYC), imax(WDATA_CYC, TURN_CYC));
    localparam int CW          = $clog2(MAX_CYC + 1);

    logic              wake_done;
    logic              timer_load;
    logic [CW-1:0]     timer_val;
    logic              timer_expire;
    strobe_t           strb;
    logic [DATA_W-1:0] dq_out;
    logic              dq_oe;
    logic [DATA_W-1:0] dq_in;
    req_t              req;

    assign req = '{wr: req_write, addr: req_addr, data: req_wdata, lanes: req_lanes};

    sac_wake_timer #(
        .WAIT_CYC (POWERUP_CYC)
    ) u_wake (
        .clk       (clk),
        .rst       (rst),
        .wake_done (wake_done)
    );

    sac_phase_timer #(
        .CW (CW)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .load_val (timer_val),
        .expire   (timer_expire)
    );

    sac_sequencer #(
        .RD_CYC    (RD_CYC),
        .WZ_CYC    (WZ_CYC),
        .WDATA_CYC (WDATA_CYC),
        .TURN_CYC  (TURN_CYC),
        .CW        (CW)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .wake_done    (wake_done),
        .req_valid    (req_valid),
        .req          (req),
        .req_ready    (req_ready),
        .timer_expire (timer_expire),
        .timer_load   (timer_load),
        .timer_val    (timer_val),
        .strb         (strb),
        .mem_addr     (mem_addr),
        .dq_out       (dq_out),
        .dq_oe        (dq_oe),
        .dq_in        (dq_in),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_rdata)
    );

    assign mem_dq   = dq_oe ? dq_out : {DATA_W{1'bz}};
    assign dq_in    = mem_dq;
    assign mem_cs_n = strb.cs_n;
    assign mem_oe_n = strb.oe_n;
    assign mem_we_n = strb.we_n;
    assign mem_lo_n = strb.lo_n;
    assign mem_hi_n = strb.hi_n;

endmodule

// File: tb/sram_access_ctrl_bench.sv
module sram_access_ctrl_bench;

    localparam int P_CLK  = 20;
    localparam int P_ACC  = 55;
    localparam int P_OE   = 5;
    localparam int P_WP   = 70;
    localparam int P_SU   = 5;
    localparam int P_WZ   = 5;
    localparam int P_TURN = 25;
    localparam int P_PWR  = 2000;

    function automatic int up(input int ns);
        int c;
        c = (ns + P_CLK - 1) / P_CLK;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_RD   = mx(up(P_ACC), up(P_OE));
    localparam int E_WZ   = up(P_WZ);
    localparam int E_WDAT = mx(mx(up(P_SU), up(P_WP) - E_WZ), 1);
    localparam int E_WLOW = E_WZ + E_WDAT;
    localparam int E_TURN = up(P_TURN);
    localparam int E_PWR  = up(P_PWR);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_lanes = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [18:0] mem_addr;
    wire  [15:0] mem_dq;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_lo_n, mem_hi_n;

    sram_access_ctrl #(
        .CLK_PERIOD_NS (P_CLK),
        .T_ACCESS_NS   (P_ACC),
        .T_OE_NS       (P_OE),
        .T_WPULSE_NS   (P_WP),
        .T_SETUP_NS    (P_SU),
        .T_WZ_NS       (P_WZ),
        .T_TURN_NS     (P_TURN),
        .POWERUP_NS    (P_PWR)
    ) u_sram_access_ctrl (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata), .req_lanes (req_lanes),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .mem_addr (mem_addr), .mem_dq (mem_dq),
        .mem_cs_n (mem_cs_n), .mem_oe_n (mem_oe_n), .mem_we_n (mem_we_n),
        .mem_lo_n (mem_lo_n), .mem_hi_n (mem_hi_n)
    );

    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int unsigned cyc = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    function automatic logic [15:0] seed_word(input int unsigned a);
        return 16'(a * 7 + 32'h1357);
    endfunction

    logic [15:0] store [int unsigned];
    int unsigned gen = 0;

    function automatic logic [15:0] peek(input int unsigned a);
        return store.exists(a) ? store[a] : seed_word(a);
    endfunction

    logic [15:0] rd_word;
    always @(mem_addr or gen) rd_word = peek(32'(mem_addr));

    logic mem_out;
    assign mem_out = !mem_cs_n && !mem_oe_n && mem_we_n;
    assign mem_dq[7:0]  = (mem_out && !mem_lo_n) ? rd_word[7:0]  : 8'bz;
    assign mem_dq[15:8] = (mem_out && !mem_hi_n) ? rd_word[15:8] : 8'bz;

    // ---------------- reference and scoreboard ----------------
    logic [15:0] ref_mem [int unsigned];

    function automatic logic [15:0] ref_peek(input int unsigned a);
        return ref_mem.exists(a) ? ref_mem[a] : seed_word(a);
    endfunction

    function automatic logic [15:0] lmask(input logic [1:0] ln);
        return {{8{ln[1]}}, {8{ln[0]}}};
    endfunction

    typedef struct {
        logic [15:0] data;
        int unsigned due;
    } exp_t;

    exp_t exp_q [$];
    logic [1:0]  cur_lanes = '0;
    logic [15:0] cur_wdata = '0;

    // ---------------- pin monitor ----------------
    int          w_run = 0;
    bit          w_prev = 0;
    bit          w_oe_bad = 0;
    logic [15:0] w_dq;
    bit          w_lo, w_hi;
    int unsigned w_addr;
    int          r_run = 0;
    bit          r_prev = 0;
    bit          r_we_bad = 0;
    bit          r_lo, r_hi;
    bit          gap_arm = 0;
    int          gap = 0;

    always @(negedge clk) begin
        if (!rst) begin
            // write side
            if (!mem_cs_n && !mem_we_n) begin
                w_run++;
                w_dq   = mem_dq;
                w_lo   = !mem_lo_n;
                w_hi   = !mem_hi_n;
                w_addr = 32'(mem_addr);
                if (!mem_oe_n) w_oe_bad = 1;
                w_prev = 1;
            end else if (w_prev) begin
                logic [15:0] t;
                t = peek(w_addr);
                if (w_lo) t[7:0]  = w_dq[7:0];
                if (w_hi) t[15:8] = w_dq[15:8];
                store[w_addr] = t;
                gen++;
                check(w_run == E_WLOW, "R4 write strobe low cycles", w_run, E_WLOW);
                check(!w_oe_bad, "R4 output enable high during write", w_oe_bad, 0);
                check({w_hi, w_lo} == cur_lanes, "R4 write lane enables", {w_hi, w_lo}, cur_lanes);
                check((w_dq & lmask(cur_lanes)) == (cur_wdata & lmask(cur_lanes)),
                      "R5 bus data at write end", w_dq & lmask(cur_lanes), cur_wdata & lmask(cur_lanes));
                w_run = 0; w_oe_bad = 0; w_prev = 0;
            end
            // read side
            if (!mem_oe_n) begin
                r_run++;
                if (mem_cs_n || !mem_we_n) r_we_bad = 1;
                r_lo = !mem_lo_n;
                r_hi = !mem_hi_n;
                r_prev = 1;
            end else if (r_prev) begin
                check(r_run == E_RD, "R2 read strobe cycles", r_run, E_RD);
                check(!r_we_bad, "R2 select low, write strobe high in read", r_we_bad, 0);
                check({r_hi, r_lo} == cur_lanes, "R2 read lane enables", {r_hi, r_lo}, cur_lanes);
                r_run = 0; r_we_bad = 0; r_prev = 0;
                gap_arm = 1; gap = 0;
            end
            // turnaround gap after a read
            if (gap_arm) begin
                if (mem_cs_n && mem_oe_n) gap++;
                else if (!mem_cs_n) begin
                    check(gap >= E_TURN + 1, "R7 idle gap after read", gap, E_TURN + 1);
                    gap_arm = 0;
                end
            end
            // response monitor
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R3 unexpected response", rsp_rdata, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(rsp_rdata == e.data, "R3 read data", rsp_rdata, e.data);
                    check(cyc == e.due, "R3 response latency", cyc, e.due);
                end
            end
        end
    end

    // ---------------- driver ----------------
    task automatic issue(input bit wr, input int unsigned a, input logic [15:0] d, input logic [1:0] ln);
        int unsigned acc;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        check({mem_cs_n, mem_oe_n, mem_we_n, mem_lo_n, mem_hi_n} == 5'b11111,
              "R8 strobes high while ready", {mem_cs_n, mem_oe_n, mem_we_n, mem_lo_n, mem_hi_n}, 5'h1f);
        req_valid = 1; req_write = wr; req_addr = 19'(a); req_wdata = d; req_lanes = ln;
        cur_lanes = ln;
        if (wr) cur_wdata = d;
        @(posedge clk);
        #1;
        acc = cyc;
        if (wr) begin
            logic [15:0] t;
            t = ref_peek(a);
            t = (t & ~lmask(ln)) | (d & lmask(ln));
            ref_mem[a] = t;
        end else begin
            exp_t e;
            e.data = ref_peek(a) & lmask(ln);
            e.due  = acc + E_RD;
            exp_q.push_back(e);
        end
        @(negedge clk);
        req_valid = 0;
        check(!req_ready, "R9 ready low during access", req_ready, 0);
    endtask

    task automatic drain();
        int n;
        n = 0;
        while ((exp_q.size() != 0 || !req_ready) && n < 100) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check({mem_cs_n, mem_oe_n, mem_we_n, mem_lo_n, mem_hi_n} == 5'b11111,
              "R1 strobes high in reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_lo_n, mem_hi_n}, 5'h1f);
        check(!req_ready, "R1 ready low in reset", req_ready, 0);
        rst = 0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == E_PWR / 2) begin
                check(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes high during wake wait",
                      {mem_cs_n, mem_oe_n, mem_we_n}, 3'h7);
            end
        end while (!req_ready && n < E_PWR + 50);
        check(n == E_PWR + 1, "R1 wake wait length", n, E_PWR + 1);

        // lane merge on one address
        issue(1, 32'h12345, 16'hBEEF, 2'b11);
        issue(0, 32'h12345, 16'h0, 2'b11);            // R3 full word
        issue(1, 32'h12345, 16'h1122, 2'b01);         // R10 low lane only
        issue(0, 32'h12345, 16'h0, 2'b11);            // expect BE22
        issue(1, 32'h12345, 16'h3344, 2'b10);         // R10 high lane only
        issue(0, 32'h12345, 16'h0, 2'b10);            // expect 3300
        issue(0, 32'h12345, 16'h0, 2'b01);            // expect 0022
        drain();
        check(store[32'h12345] == 16'h3322, "R10 stored word after partial writes", store[32'h12345], 16'h3322);

        // empty mask
        issue(1, 32'h12345, 16'hFFFF, 2'b00);
        drain();
        check(store[32'h12345] == 16'h3322, "R6 empty-mask write leaves word", store[32'h12345], 16'h3322);
        issue(0, 32'h12345, 16'h0, 2'b00);            // R6 read returns 0
        issue(0, 32'h12345, 16'h0, 2'b11);

        // address extremes, unwritten
        issue(0, 32'h7FFFF, 16'h0, 2'b11);
        issue(0, 32'h00000, 16'h0, 2'b11);

        // read directly followed by write (R7 gap)
        issue(0, 32'h00100, 16'h0, 2'b11);
        issue(1, 32'h00100, 16'hA55A, 2'b11);
        issue(0, 32'h00100, 16'h0, 2'b11);

        // mixed traffic
        for (int i = 0; i < 16; i++) begin
            int unsigned a;
            a = (i * 32'h8A3D) & 32'h7FFFF;
            issue(1, a, 16'(i * 16'h1F3 + 16'h0C01), 2'(i % 3 + 1));
            issue(0, a, 16'h0, 2'b11);
            issue(0, a ^ 32'h40000, 16'h0, 2'(3 - i % 3));
        end
        drain();
        check(exp_q.size() == 0, "R3 every read answered", exp_q.size(), 0);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule